// File: doc/BRIEF.md
# Prime Implicant Generator Engine

This engine takes a Boolean function of a few variables (four by default), given as a one-hot minterm mask of required ones and a second mask of don't-care minterms. It works out every prime implicant of that function by repeated tabular cube merging. A start pulse loads both masks. The engine then runs one merging pass per dash count. In each pass, every cube that holds that many dashes is tested against its one-bit neighbours. A cube that finds a neighbour is marked as not prime, and the wider merged cube is recorded. Passes stop as soon as a pass produces no merge. A final scan then streams out the surviving cubes, one per cycle, each flagged by a valid pulse. A done pulse follows, and the number of primes is left on a count output.

Cubes are stored as presence flags, one for each point of the ternary cube space (3^N entries). The same merged cube reached by two different pairs therefore collapses into one entry without extra logic. Each variable position is encoded as a ternary digit: 0 is a literal 0, 1 is a literal 1, 2 is a dash. Bit i of a minterm number maps to digit i, and digit i has weight 3^i. The cube index is the sum of the digits times their weights, and primes are emitted in ascending order of this index.

Top module: `prime_implicant_engine`

## Requirements
- R1: After reset, busy_o, prime_valid_o and done_o are low and prime_count_o is zero.
- R2: An emitted cube shows variable i as a dash when prime_dash_o[i] is 1. Otherwise it shows the literal prime_value_o[i]. A value bit is always 0 under a dash. Bit i corresponds to bit i of the minterm number (bit 0 is the least significant variable).
- R3: The emitted set is exactly the set of cubes that lie wholly inside on-set ∪ don't-care set and cannot be widened by turning any one literal into a dash. For on-set {0,1,2,3,5,8,10,11,13,15} this gives seven cubes.
- R4: Don't-care minterms take part in merging. A prime that covers no on-set minterm is not emitted.
- R5: Primes are emitted one per valid pulse, in strictly ascending cube index, where index = Σ d_i·3^i with d_i = 0 for a literal 0, 1 for a literal 1 and 2 for a dash. Each cube appears only once.
- R6: done_o pulses for one cycle, with busy_o low, after the last prime. prime_count_o then equals the number of valid pulses of the run and holds until the next accepted start.
- R7: start_i is ignored while busy_o is high. Masks presented at that time do not affect the result.
- R8: An all-zero on-set yields no primes. An all-ones on-set yields one cube with every variable a dash.
- R9: Minterms that differ in more than one variable (diagonal squares) are never merged into a common cube.
- R10: busy_o is high in the cycle after an accepted start. done_o arrives within 3^N·(N+2)+3 cycles of the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run when idle |
| on_mask_i | input | 2^NVARS | Required-one minterms, bit m = minterm m |
| dc_mask_i | input | 2^NVARS | Don't-care minterms |
| busy_o | output | 1 | Run in progress |
| prime_valid_o | output | 1 | A prime is on the value/dash outputs this cycle |
| prime_value_o | output | NVARS | Literal values of the prime |
| prime_dash_o | output | NVARS | Dash positions of the prime |
| done_o | output | 1 | One-cycle end-of-run pulse |
| prime_count_o | output | clog2(3^NVARS+1) | Primes emitted in the last run |

## Verification
busy_o rises in the first cycle after the accepted start. The merge passes then take 3^N cycles each, and the emission scan takes another 3^N cycles. A prime therefore appears a data-dependent number of cycles after the start, so the bench samples prime_valid_o at every falling edge from the cycle after the start until done_o. It compares the captured sequence, in order, against a cube list it computes itself by exhaustive widening tests. It also checks that done_o arrives within the R10 bound, and it reads prime_count_o in the done cycle.

// File: rtl/pig_pkg.sv
package pig_pkg;

   typedef logic [1:0] trit_t;

   localparam trit_t TRIT_LO   = 2'd0;
   localparam trit_t TRIT_HI   = 2'd1;
   localparam trit_t TRIT_DASH = 2'd2;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_MERGE,
      ST_EMIT,
      ST_FIN
   } eng_state_e;

   function automatic int pow3(input int n);
      int r;
      r = 1;
      for (int i = 0; i < n; i++) r = r * 3;
      return r;
   endfunction

   // ternary index of a fully specified minterm
   function automatic int bin_to_cube(input int m, input int n);
      int acc;
      acc = 0;
      for (int i = 0; i < n; i++)
         if (((m >> i) & 1) == 1) acc = acc + pow3(i);
      return acc;
   endfunction

endpackage

// File: rtl/pig_trit_counter.sv
module pig_trit_counter
   import pig_pkg::*;
#(
   parameter int NDIG = 4,
   parameter int IW   = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_i,
   input  logic                  inc_i,
   output logic [NDIG-1:0][1:0]  digs_o,
   output logic [IW-1:0]         idx_o,
   output logic                  last_o
);

   logic [NDIG-1:0][1:0] digs_q;
   logic [NDIG-1:0][1:0] digs_d;
   logic [NDIG-1:0]      top_dig;

   always_comb begin
      logic carry;
      carry  = 1'b1;
      digs_d = digs_q;
      for (int i = 0; i < NDIG; i++) begin
         if (carry) begin
            if (digs_q[i] == TRIT_DASH) begin
               digs_d[i] = TRIT_LO;
            end else begin
               digs_d[i] = digs_q[i] + 2'd1;
               carry     = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     digs_q <= '0;
      else if (clr_i) digs_q <= '0;
      else if (inc_i) digs_q <= digs_d;
   end

   generate
      for (genvar gi = 0; gi < NDIG; gi++) begin : g_top
         assign top_dig[gi] = (digs_q[gi] == TRIT_DASH);
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NDIG; i++)
         idx_o = idx_o + IW'(digs_q[i]) * IW'(pow3(i));
   end

   assign last_o = &top_dig;
   assign digs_o = digs_q;

endmodule

// File: rtl/pig_merge_probe.sv
module pig_merge_probe
   import pig_pkg::*;
#(
   parameter int NVARS = 4,
   parameter int NCUBE = 81,
   parameter int IW    = 7
) (
   input  logic [NVARS-1:0][1:0]    digs_i,
   input  logic [IW-1:0]            idx_i,
   input  logic [NCUBE-1:0]         present_i,
   output logic [NVARS-1:0]         can_merge_o,
   output logic [NVARS-1:0][IW-1:0] merged_idx_o
);

   generate
      for (genvar gi = 0; gi < NVARS; gi++) begin : g_pos
         localparam logic [IW-1:0] WGT = IW'(pow3(gi));
         logic          lit_lo;
         logic [IW-1:0] partner;
         assign lit_lo  = (digs_i[gi] == TRIT_LO);
         // neighbour across position gi: the same cube with that literal flipped
         assign partner = lit_lo ? (idx_i + WGT) : (idx_i - WGT);
         assign merged_idx_o[gi] = lit_lo ? (idx_i + WGT + WGT) : (idx_i + WGT);
         assign can_merge_o[gi]  = (digs_i[gi] != TRIT_DASH) && present_i[partner];
      end
   endgenerate

endmodule

// File: rtl/pig_onset_check.sv
module pig_onset_check
   import pig_pkg::*;
#(
   parameter int NVARS = 4,
   parameter int NMIN  = 16
) (
   input  logic [NVARS-1:0][1:0] digs_i,
   input  logic [NMIN-1:0]       on_i,
   output logic                  hit_o
);

   logic [NMIN-1:0] hit_v;

   generate
      for (genvar gm = 0; gm < NMIN; gm++) begin : g_min
         logic [NVARS-1:0] pos_ok;
         for (genvar gi = 0; gi < NVARS; gi++) begin : g_pos
            localparam bit MBIT = ((gm >> gi) & 1) == 1;
            assign pos_ok[gi] = (digs_i[gi] == TRIT_DASH) || (digs_i[gi][0] == MBIT);
         end
         assign hit_v[gm] = on_i[gm] && (&pos_ok);
      end
   endgenerate

   assign hit_o = |hit_v;

endmodule

// File: rtl/prime_implicant_engine.sv
module prime_implicant_engine
   import pig_pkg::*;
#(
   parameter int NVARS = 4,
   localparam int NMIN  = 1 << NVARS,
   localparam int NCUBE = pow3(NVARS),
   localparam int IW    = $clog2(NCUBE),
   localparam int CW    = $clog2(NCUBE + 1),
   localparam int KW    = $clog2(NVARS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NMIN-1:0]   on_mask_i,
   input  logic [NMIN-1:0]   dc_mask_i,
   output logic              busy_o,
   output logic              prime_valid_o,
   output logic [NVARS-1:0]  prime_value_o,
   output logic [NVARS-1:0]  prime_dash_o,
   output logic              done_o,
   output logic [CW-1:0]     prime_count_o
);

   generate
      if (NVARS < 1 || NVARS > 6) begin : g_bad_nvars
         $error("prime_implicant_engine: NVARS must lie in 1..6");
      end
   endgenerate

   eng_state_e state_q;
   logic [NCUBE-1:0] present_q;
   logic [NCUBE-1:0] covered_q;
   logic [NMIN-1:0]  on_q;
   logic [KW-1:0]    pass_q;
   logic             grew_q;
   logic [CW-1:0]    count_q;

   logic [NVARS-1:0][1:0]    cur_digs;
   logic [IW-1:0]            cur_idx;
   logic                     cur_last;
   logic [NVARS-1:0]         can_merge;
   logic [NVARS-1:0][IW-1:0] merged_idx;
   logic                     on_hit;
   logic [NVARS-1:0]         cur_dash;
   logic [NVARS-1:0]         cur_val;
   logic [KW-1:0]            cur_ndash;
   logic                     in_pass;
   logic                     merge_now;
   logic                     grew_now;
   logic                     is_prime;
   logic                     cnt_clr;
   logic                     cnt_inc;

   generate
      for (genvar gi = 0; gi < NVARS; gi++) begin : g_lit
         assign cur_dash[gi] = (cur_digs[gi] == TRIT_DASH);
         assign cur_val[gi]  = (cur_digs[gi] == TRIT_HI);
      end
   endgenerate

   always_comb begin
      cur_ndash = '0;
      for (int i = 0; i < NVARS; i++) cur_ndash = cur_ndash + KW'(cur_dash[i]);
   end

   assign cnt_clr = (state_q == ST_IDLE) || ((state_q == ST_MERGE) && cur_last);
   assign cnt_inc = (state_q == ST_MERGE) || (state_q == ST_EMIT);

   pig_trit_counter #(.NDIG(NVARS), .IW(IW)) i_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cnt_clr),
      .inc_i  (cnt_inc),
      .digs_o (cur_digs),
      .idx_o  (cur_idx),
      .last_o (cur_last)
   );

   pig_merge_probe #(.NVARS(NVARS), .NCUBE(NCUBE), .IW(IW)) i_probe (
      .digs_i       (cur_digs),
      .idx_i        (cur_idx),
      .present_i    (present_q),
      .can_merge_o  (can_merge),
      .merged_idx_o (merged_idx)
   );

   pig_onset_check #(.NVARS(NVARS), .NMIN(NMIN)) i_onchk (
      .digs_i (cur_digs),
      .on_i   (on_q),
      .hit_o  (on_hit)
   );

   assign in_pass   = present_q[cur_idx] && (cur_ndash == pass_q);
   assign merge_now = in_pass && (|can_merge);
   assign grew_now  = grew_q || merge_now;
   assign is_prime  = present_q[cur_idx] && !covered_q[cur_idx] && on_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         present_q     <= '0;
         covered_q     <= '0;
         on_q          <= '0;
         pass_q        <= '0;
         grew_q        <= 1'b0;
         count_q       <= '0;
         prime_valid_o <= 1'b0;
         prime_value_o <= '0;
         prime_dash_o  <= '0;
         done_o        <= 1'b0;
      end else begin
         prime_valid_o <= 1'b0;
         done_o        <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  on_q      <= on_mask_i;
                  covered_q <= '0;
                  count_q   <= '0;
                  pass_q    <= '0;
                  grew_q    <= 1'b0;
                  present_q <= '0;
                  for (int m = 0; m < NMIN; m++)
                     present_q[bin_to_cube(m, NVARS)] <= on_mask_i[m] | dc_mask_i[m];
                  state_q   <= ST_MERGE;
               end
            end
            ST_MERGE: begin
               if (in_pass) begin
                  for (int i = 0; i < NVARS; i++)
                     if (can_merge[i]) present_q[merged_idx[i]] <= 1'b1;
                  if (|can_merge) covered_q[cur_idx] <= 1'b1;
               end
               if (cur_last) begin
                  grew_q <= 1'b0;
                  if (grew_now) pass_q <= pass_q + KW'(1);
                  else          state_q <= ST_EMIT;
               end else begin
                  grew_q <= grew_now;
               end
            end
            ST_EMIT: begin
               prime_valid_o <= is_prime;
               prime_value_o <= cur_val;
               prime_dash_o  <= cur_dash;
               if (is_prime) count_q <= count_q + CW'(1);
               if (cur_last) state_q <= ST_FIN;
            end
            ST_FIN: begin
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o        = (state_q != ST_IDLE);
   assign prime_count_o = count_q;

endmodule

// File: rtl/pig_checker.sv
module pig_checker
   import pig_pkg::*;
#(
   parameter int NVARS = 4,
   localparam int NCUBE = pow3(NVARS),
   localparam int IW    = $clog2(NCUBE),
   localparam int CW    = $clog2(NCUBE + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             prime_valid_o,
   input logic [NVARS-1:0] prime_value_o,
   input logic [NVARS-1:0] prime_dash_o,
   input logic             done_o,
   input logic [CW-1:0]    prime_count_o
);

   logic [IW-1:0] emit_idx;
   logic [IW-1:0] last_idx;
   logic          have_last;

   always_comb begin
      emit_idx = '0;
      for (int i = 0; i < NVARS; i++)
         emit_idx = emit_idx + (prime_dash_o[i] ? IW'(2) : IW'(prime_value_o[i])) * IW'(pow3(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_last <= 1'b0;
         last_idx  <= '0;
      end else if (!busy_o && start_i) begin
         have_last <= 1'b0;
      end else if (prime_valid_o) begin
         have_last <= 1'b1;
         last_idx  <= emit_idx;
      end
   end

   assert_valid_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      prime_valid_o |-> busy_o);

   assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prime_valid_o && have_last) |-> (emit_idx > last_idx));

   assert_clean_literals_R2: assert property (@(posedge clk) disable iff (!rst_n)
      prime_valid_o |-> ((prime_value_o & prime_dash_o) == '0));

   assert_run_not_aborted_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (busy_o || done_o));

   assert_done_closes_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !prime_valid_o && $past(busy_o)));

   assert_count_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(prime_count_o));

endmodule

bind prime_implicant_engine pig_checker #(.NVARS(NVARS)) i_pig_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .busy_o        (busy_o),
   .prime_valid_o (prime_valid_o),
   .prime_value_o (prime_value_o),
   .prime_dash_o  (prime_dash_o),
   .done_o        (done_o),
   .prime_count_o (prime_count_o)
);

// File: tb/test_prime_implicant_engine.sv
module test_prime_implicant_engine;

   localparam int CLK_PERIOD = 10;
   localparam int NV   = 4;
   localparam int NM   = 16;
   localparam int NC   = 81;
   localparam int CW   = 7;
   localparam int LIMIT = NC * (NV + 2) + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [NM-1:0] on_mask_i = '0;
   logic [NM-1:0] dc_mask_i = '0;
   logic          busy_o;
   logic          prime_valid_o;
   logic [NV-1:0] prime_value_o;
   logic [NV-1:0] prime_dash_o;
   logic          done_o;
   logic [CW-1:0] prime_count_o;

   int n_checks = 0;
   int n_fails  = 0;

   int got_n, exp_n, count_at_done, run_cycles;
   bit saw_done;
   logic [NV-1:0] got_v [NC];
   logic [NV-1:0] got_d [NC];
   logic [NV-1:0] exp_v [NC];
   logic [NV-1:0] exp_d [NC];

   always #(CLK_PERIOD/2) clk = ~clk;

   prime_implicant_engine #(.NVARS(NV)) i_prime_implicant_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .on_mask_i(on_mask_i), .dc_mask_i(dc_mask_i),
      .busy_o(busy_o), .prime_valid_o(prime_valid_o),
      .prime_value_o(prime_value_o), .prime_dash_o(prime_dash_o),
      .done_o(done_o), .prime_count_o(prime_count_o)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit inside_f(input logic [NV-1:0] v, input logic [NV-1:0] d,
                                   input logic [NM-1:0] f);
      for (int m = 0; m < NM; m++)
         if (((NV'(m) & ~d) == (v & ~d)) && !f[m]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit touches(input logic [NV-1:0] v, input logic [NV-1:0] d,
                                  input logic [NM-1:0] f);
      for (int m = 0; m < NM; m++)
         if (((NV'(m) & ~d) == (v & ~d)) && f[m]) return 1'b1;
      return 1'b0;
   endfunction

   // independent model: widen-test every cube of the ternary space in index order
   task automatic build_model(input logic [NM-1:0] on, input logic [NM-1:0] dc);
      exp_n = 0;
      for (int c = 0; c < NC; c++) begin
         logic [NV-1:0] v, d;
         bit prime;
         int r;
         r = c; v = '0; d = '0;
         for (int i = 0; i < NV; i++) begin
            if (r % 3 == 2) d[i] = 1'b1;
            else if (r % 3 == 1) v[i] = 1'b1;
            r = r / 3;
         end
         prime = inside_f(v, d, on | dc) && touches(v, d, on);
         for (int i = 0; i < NV; i++)
            if (prime && !d[i] && inside_f(v & ~(NV'(1) << i), d | (NV'(1) << i), on | dc))
               prime = 1'b0;
         if (prime) begin
            exp_v[exp_n] = v;
            exp_d[exp_n] = d;
            exp_n++;
         end
      end
   endtask

   task automatic run(input logic [NM-1:0] on, input logic [NM-1:0] dc,
                      input bit inject, input logic [NM-1:0] alt);
      @(negedge clk);
      on_mask_i = on; dc_mask_i = dc; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o === 1'b1, "R10", "busy after start", int'(busy_o), 1);
      got_n = 0; run_cycles = 1; saw_done = 1'b0;
      while (run_cycles <= LIMIT) begin
         if (done_o) begin
            saw_done = 1'b1;
            count_at_done = int'(prime_count_o);
            break;
         end
         if (prime_valid_o && got_n < NC) begin
            got_v[got_n] = prime_value_o;
            got_d[got_n] = prime_dash_o;
            got_n++;
         end
         if (inject && (run_cycles == 5 || run_cycles == 200)) begin
            on_mask_i = alt; dc_mask_i = alt; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         run_cycles++;
      end
      start_i = 1'b0;
      check(saw_done, "R10", "done within bound", run_cycles, LIMIT);
   endtask

   task automatic compare(input string tag);
      check(got_n == exp_n, tag, "prime count", got_n, exp_n);
      check(count_at_done == got_n, "R6", "count output", count_at_done, got_n);
      for (int k = 0; k < got_n && k < exp_n; k++) begin
         check(got_v[k] == exp_v[k], tag, $sformatf("value of prime %0d", k),
               int'(got_v[k]), int'(exp_v[k]));
         check(got_d[k] == exp_d[k], tag, $sformatf("dash of prime %0d", k),
               int'(got_d[k]), int'(exp_d[k]));
         check((got_v[k] & got_d[k]) == '0, "R2", "value under dash", int'(got_v[k]), 0);
      end
   endtask

   task automatic test_reset();
      check(busy_o === 1'b0, "R1", "busy", int'(busy_o), 0);
      check(prime_valid_o === 1'b0, "R1", "valid", int'(prime_valid_o), 0);
      check(done_o === 1'b0, "R1", "done", int'(done_o), 0);
      check(prime_count_o === '0, "R1", "count", int'(prime_count_o), 0);
   endtask

   task automatic test_textbook();
      logic [NV-1:0] fv [7] = '{4'b0000, 4'b0001, 4'b1101, 4'b1011, 4'b0010, 4'b0000, 4'b0101};
      logic [NV-1:0] fd [7] = '{4'b0011, 4'b0100, 4'b0010, 4'b0100, 4'b1001, 4'b1010, 4'b1000};
      build_model(16'hAD2F, 16'h0000);
      run(16'hAD2F, 16'h0000, 1'b0, '0);
      compare("R3");
      check(got_n == 7, "R3", "seven primes", got_n, 7);
      for (int k = 0; k < 7 && k < got_n; k++)
         check(got_v[k] == fv[k] && got_d[k] == fd[k], "R5", $sformatf("ordered prime %0d", k),
               int'({got_v[k], got_d[k]}), int'({fv[k], fd[k]}));
   endtask

   task automatic test_empty_full();
      build_model(16'h0000, 16'h0000);
      run(16'h0000, 16'h0000, 1'b0, '0);
      compare("R8");
      check(count_at_done == 0, "R8", "empty count", count_at_done, 0);
      build_model(16'hFFFF, 16'h0000);
      run(16'hFFFF, 16'h0000, 1'b0, '0);
      compare("R8");
      check(got_n == 1 && got_d[0] == 4'hF && got_v[0] == 4'h0, "R8", "all-dash cube",
            int'({got_v[0], got_d[0]}), 8'h0F);
   endtask

   task automatic test_dontcare();
      build_model(16'h888A, 16'h0025);
      run(16'h888A, 16'h0025, 1'b0, '0);
      compare("R4");
      build_model(16'h0001, 16'h8000);
      run(16'h0001, 16'h8000, 1'b0, '0);
      compare("R4");
      check(got_n == 1 && got_v[0] == 4'h0 && got_d[0] == 4'h0, "R4", "dc-only cube dropped",
            got_n, 1);
   endtask

   task automatic test_diagonal_parity();
      build_model(16'h0009, 16'h0000);
      run(16'h0009, 16'h0000, 1'b0, '0);
      compare("R9");
      check(got_n == 2, "R9", "diagonal stays apart", got_n, 2);
      build_model(16'h6996, 16'h0000);
      run(16'h6996, 16'h0000, 1'b0, '0);
      compare("R9");
      check(got_n == 8, "R9", "odd parity count", got_n, 8);
   endtask

   task automatic test_start_busy();
      build_model(16'hAD2F, 16'h0000);
      run(16'hAD2F, 16'h0000, 1'b1, 16'hFFFF);
      compare("R7");
      check(got_n == 7, "R7", "masks during run ignored", got_n, 7);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_textbook();
      test_empty_full();
      test_dontcare();
      test_diagonal_parity();
      test_start_busy();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule